// File: doc/BRIEF.md
# Banked Memory Wavefront Counter

This block looks at one shared-memory request issued together by 32 lanes and works out how many serialized passes over the banked storage that request costs. Each lane presents a byte address and an active bit, and the request carries one access-size code. Lanes are grouped into phases according to the size. Lanes inside a phase can collide in a bank. Lanes in different phases never do.

Once a start strobe is accepted, the block captures the request. It then evaluates one phase per clock and emits a per-phase wavefront figure. One cycle after the last phase it pulses a completion flag together with four results: the total wavefronts, the conflict-free ideal, the excess between the two, and a flag for misaligned lanes. A performance model or a hardware profiling path uses these figures to measure how much bank conflicts cost, for example to compare a plain layout against an XOR-permuted layout of the same tile.

Top module: `bank_wavefront_counter`

## Requirements
- R1: `size_code` selects the lane grouping. Code 0 means 4-byte accesses, with all 32 lanes in one phase. Code 1 means 8-byte accesses in 2 phases: lanes 0-15, then 16-31. Code 2 means 16-byte accesses in 4 phases, with lane i in phase i/8. Code 3 behaves exactly like code 2. Phases are reported in increasing order, starting at 0.
- R2: A lane's bank is address bits [6:L], where L is 2, 3 or 4 for 4-, 8- and 16-byte accesses. A phase needs as many wavefronts as the largest number of distinct addresses that its counted lanes place in any one bank. Lanes sharing one address count once. A 16-byte phase whose 8 lanes all hit one bank at distinct addresses therefore needs 8.
- R3: Lanes in different phases never add wavefronts to each other, even when they use the same bank with different addresses.
- R4: A lane is counted only if it is active and its address is a multiple of the access size. An active misaligned lane is excluded from every count and makes `misalign_err` read 1 at completion.
- R5: `ideal_wf` is the number of phases that hold at least one counted lane. `excess_wf` equals `total_wf` minus `ideal_wf`. A request with no counted lane reports all zeros.
- R6: After the edge that accepts `start`, the result for phase p is shown with `phase_vld` high in the (p+2)-th cycle. `done` is high for exactly the one cycle that follows the last phase. The four results change only when `done` rises and hold until the next completion.
- R7: A `start` seen while a request is still being evaluated or awaiting its completion pulse is ignored. That request's results are unaffected, and no extra phases appear.
- R8: A `start` presented in the cycle where `done` is high is accepted, and the new request proceeds with correct results.
- R9: During and right after reset, every output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled when idle |
| size_code | input | 2 | Access size: 0 = 4 B, 1 = 8 B, 2 or 3 = 16 B |
| lane_addr | input | LANES*AW | Byte address of lane i at bits [i*AW +: AW] |
| lane_act | input | LANES | Active-lane mask |
| phase_vld | output | 1 | One-cycle flag: phase result is valid |
| phase_idx | output | 2 | Index of the reported phase |
| phase_wf | output | $clog2(LANES+1) | Wavefronts needed by the reported phase |
| done | output | 1 | One-cycle completion flag |
| total_wf | output | $clog2(LANES+1) | Sum of phase wavefronts |
| ideal_wf | output | 3 | Phases holding at least one counted lane |
| excess_wf | output | $clog2(LANES+1) | total_wf minus ideal_wf |
| misalign_err | output | 1 | An active lane was misaligned |

## Verification
Completion of one request and acceptance of the next can fall in the same cycle. The bench provokes this by driving a new `start` with a different size and address pattern in the cycle it observes `done` high. It then judges both requests: the completing request's totals must be correct in that cycle, and every phase and total of the follow-on request must match the model. A second overlap is a strobe arriving while phases are still being emitted. Its check is that the in-flight figures and the phase count stay exactly those of the first request.

// File: rtl/bwc_pkg.sv
package bwc_pkg;
  localparam int MAX_PH = 4;
  localparam int PH_W   = 2;

  typedef enum logic [1:0] {
    SZ_4B    = 2'd0,
    SZ_8B    = 2'd1,
    SZ_16B   = 2'd2,
    SZ_16B_A = 2'd3
  } size_e;

  // code 3 is an alias of the 16-byte grouping
  function automatic size_e norm_size(input logic [1:0] code);
    return (code == 2'd3) ? SZ_16B : size_e'(code);
  endfunction
endpackage

// File: rtl/bwc_lane_qual.sv
// Per-lane qualification: phase membership and alignment.
module bwc_lane_qual import bwc_pkg::*; #(
  parameter int LANES = 32,
  parameter int LOWB  = 5
) (
  input  logic [LANES*LOWB-1:0] low_flat,
  input  logic [LANES-1:0]      act,
  input  logic [1:0]            szc,
  input  logic [PH_W-1:0]       ph,
  output logic [LANES-1:0]      use_o,
  output logic [LANES-1:0]      bad_o
);
  localparam int LANE_LOG = $clog2(LANES);

  logic [LOWB-1:0] lowmask;
  assign lowmask = LOWB'((LOWB'(4) << szc) - LOWB'(1));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_LOG:0] grp;
    logic              inph;
    logic              aligned;
    assign grp     = (LANE_LOG+1)'(i) >> (LANE_LOG - int'(szc));
    assign inph    = (grp == (LANE_LOG+1)'(ph));
    assign aligned = ((low_flat[i*LOWB +: LOWB] & lowmask) == '0);
    assign use_o[i] = act[i] & inph & aligned;
    assign bad_o[i] = act[i] & inph & ~aligned;
  end
endmodule

// File: rtl/bwc_phase_eval.sv
// Wavefronts of one phase: worst bank by distinct address count.
module bwc_phase_eval #(
  parameter int LANES   = 32,
  parameter int AW      = 32,
  parameter int ROW_LOG = 7,
  parameter int CW      = 6
) (
  input  logic [LANES*AW-1:0] addr_flat,
  input  logic [LANES-1:0]    use_i,
  output logic [CW-1:0]       wf,
  output logic                any_o
);
  logic [LANES-1:0] first;

  // a lane is the first holder of its address among earlier counted lanes
  always_comb begin
    for (int j = 0; j < LANES; j++) begin
      first[j] = use_i[j];
      for (int k = 0; k < j; k++) begin
        if (use_i[k] && (addr_flat[k*AW +: AW] == addr_flat[j*AW +: AW]))
          first[j] = 1'b0;
      end
    end
  end

  // aligned lanes share a bank exactly when their low row bits match
  always_comb begin
    logic [CW-1:0] cnt;
    wf = '0;
    for (int i = 0; i < LANES; i++) begin
      cnt = '0;
      for (int j = 0; j < LANES; j++) begin
        if (first[j] && (addr_flat[i*AW +: ROW_LOG] == addr_flat[j*AW +: ROW_LOG]))
          cnt = cnt + CW'(1);
      end
      if (use_i[i] && (cnt > wf))
        wf = cnt;
    end
  end

  assign any_o = |use_i;
endmodule

// File: rtl/bwc_seq.sv
// Request capture, phase stepping, accumulation and result registers.
module bwc_seq import bwc_pkg::*; #(
  parameter int LANES = 32,
  parameter int AW    = 32,
  parameter int CW    = 6,
  parameter int IW    = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          size_in,
  input  logic [LANES*AW-1:0] addr_in,
  input  logic [LANES-1:0]    act_in,
  input  logic [CW-1:0]       ph_wf,
  input  logic                ph_any,
  input  logic                ph_bad,
  output logic [LANES*AW-1:0] cap_addr,
  output logic [LANES-1:0]    cap_act,
  output size_e               cap_sz,
  output logic [PH_W-1:0]     ph,
  output logic                phase_vld,
  output logic [PH_W-1:0]     phase_idx,
  output logic [CW-1:0]       phase_wf,
  output logic                done,
  output logic [CW-1:0]       total_wf,
  output logic [IW-1:0]       ideal_wf,
  output logic [CW-1:0]       excess_wf,
  output logic                misalign_err
);
  logic            busy;
  logic            pend;
  logic [CW-1:0]   acc_t;
  logic [IW-1:0]   acc_i;
  logic            acc_e;
  logic [PH_W-1:0] last_ph;

  assign last_ph = PH_W'((3'd1 << cap_sz) - 3'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy         <= 1'b0;
      pend         <= 1'b0;
      cap_addr     <= '0;
      cap_act      <= '0;
      cap_sz       <= SZ_4B;
      ph           <= '0;
      acc_t        <= '0;
      acc_i        <= '0;
      acc_e        <= 1'b0;
      phase_vld    <= 1'b0;
      phase_idx    <= '0;
      phase_wf     <= '0;
      done         <= 1'b0;
      total_wf     <= '0;
      ideal_wf     <= '0;
      excess_wf    <= '0;
      misalign_err <= 1'b0;
    end else begin
      phase_vld <= 1'b0;
      done      <= 1'b0;
      if (busy) begin
        phase_vld <= 1'b1;
        phase_idx <= ph;
        phase_wf  <= ph_wf;
        acc_t     <= acc_t + ph_wf;
        acc_i     <= acc_i + IW'(ph_any);
        acc_e     <= acc_e | ph_bad;
        if (ph == last_ph) begin
          busy <= 1'b0;
          pend <= 1'b1;
        end else begin
          ph <= ph + PH_W'(1);
        end
      end else if (pend) begin
        pend         <= 1'b0;
        done         <= 1'b1;
        total_wf     <= acc_t;
        ideal_wf     <= acc_i;
        excess_wf    <= acc_t - CW'(acc_i);
        misalign_err <= acc_e;
      end else if (start) begin
        cap_addr <= addr_in;
        cap_act  <= act_in;
        cap_sz   <= norm_size(size_in);
        ph       <= '0;
        acc_t    <= '0;
        acc_i    <= '0;
        acc_e    <= 1'b0;
        busy     <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/bank_wavefront_counter.sv
module bank_wavefront_counter import bwc_pkg::*; #(
  parameter int LANES = 32,
  parameter int AW    = 32,
  localparam int CW   = $clog2(LANES + 1),
  localparam int IW   = $clog2(MAX_PH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [1:0]          size_code,
  input  logic [LANES*AW-1:0] lane_addr,
  input  logic [LANES-1:0]    lane_act,
  output logic                phase_vld,
  output logic [PH_W-1:0]     phase_idx,
  output logic [CW-1:0]       phase_wf,
  output logic                done,
  output logic [CW-1:0]       total_wf,
  output logic [IW-1:0]       ideal_wf,
  output logic [CW-1:0]       excess_wf,
  output logic                misalign_err
);
  localparam int ROW_LOG = $clog2(LANES) + 2;
  localparam int LOWB    = 5;

  logic [LANES*AW-1:0]   cap_addr;
  logic [LANES-1:0]      cap_act;
  size_e                 cap_sz;
  logic [PH_W-1:0]       ph;
  logic [LANES*LOWB-1:0] low_flat;
  logic [LANES-1:0]      use_v;
  logic [LANES-1:0]      bad_v;
  logic [CW-1:0]         ph_wf;
  logic                  ph_any;

  for (genvar i = 0; i < LANES; i++) begin : g_low
    assign low_flat[i*LOWB +: LOWB] = cap_addr[i*AW +: LOWB];
  end

  bwc_seq #(.LANES(LANES), .AW(AW), .CW(CW), .IW(IW)) u_seq (
    .clk(clk), .rst(rst), .start(start), .size_in(size_code),
    .addr_in(lane_addr), .act_in(lane_act),
    .ph_wf(ph_wf), .ph_any(ph_any), .ph_bad(|bad_v),
    .cap_addr(cap_addr), .cap_act(cap_act), .cap_sz(cap_sz), .ph(ph),
    .phase_vld(phase_vld), .phase_idx(phase_idx), .phase_wf(phase_wf),
    .done(done), .total_wf(total_wf), .ideal_wf(ideal_wf),
    .excess_wf(excess_wf), .misalign_err(misalign_err)
  );

  bwc_lane_qual #(.LANES(LANES), .LOWB(LOWB)) u_qual (
    .low_flat(low_flat), .act(cap_act), .szc(cap_sz), .ph(ph),
    .use_o(use_v), .bad_o(bad_v)
  );

  bwc_phase_eval #(.LANES(LANES), .AW(AW), .ROW_LOG(ROW_LOG), .CW(CW)) u_eval (
    .addr_flat(cap_addr), .use_i(use_v), .wf(ph_wf), .any_o(ph_any)
  );
endmodule

// File: rtl/bwc_checker.sv
module bwc_checker import bwc_pkg::*; #(
  parameter int LANES = 32,
  parameter int CW    = 6,
  parameter int IW    = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            phase_vld,
  input logic [PH_W-1:0] phase_idx,
  input logic [CW-1:0]   phase_wf,
  input logic            done,
  input logic [CW-1:0]   total_wf,
  input logic [IW-1:0]   ideal_wf,
  input logic [CW-1:0]   excess_wf,
  input logic            misalign_err
);
  a_r1_idx_step: assert property (@(posedge clk) disable iff (rst)
    (phase_vld && $past(phase_vld)) |-> (phase_idx == PH_W'($past(phase_idx) + 1'b1)));

  a_r2_wf_bound: assert property (@(posedge clk) disable iff (rst)
    phase_vld |-> (phase_wf <= CW'(LANES)));

  a_r5_ideal_le_total: assert property (@(posedge clk) disable iff (rst)
    done |-> ((CW'(ideal_wf) <= total_wf) && (excess_wf <= total_wf)));

  a_r5_empty_zero: assert property (@(posedge clk) disable iff (rst)
    (done && (ideal_wf == '0)) |-> (total_wf == '0));

  a_r5_ideal_cap: assert property (@(posedge clk) disable iff (rst)
    done |-> (ideal_wf <= IW'(MAX_PH)));

  a_r6_done_after_phase: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(phase_vld));

  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r6_hold_results: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(total_wf) && $stable(ideal_wf) && $stable(excess_wf) && $stable(misalign_err)));

  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    done |-> !phase_vld);
endmodule

bind bank_wavefront_counter bwc_checker #(.LANES(LANES), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst(rst), .phase_vld(phase_vld), .phase_idx(phase_idx),
  .phase_wf(phase_wf), .done(done), .total_wf(total_wf), .ideal_wf(ideal_wf),
  .excess_wf(excess_wf), .misalign_err(misalign_err)
);

// File: tb/bank_wavefront_counter_tb.sv
module bank_wavefront_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [1:0]    size_code = 2'd0;
  logic [1023:0] lane_addr = '0;
  logic [31:0]   lane_act = '0;
  logic          phase_vld;
  logic [1:0]    phase_idx;
  logic [5:0]    phase_wf;
  logic          done;
  logic [5:0]    total_wf;
  logic [2:0]    ideal_wf;
  logic [5:0]    excess_wf;
  logic          misalign_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_wavefront_counter dut_i (
    .clk(clk), .rst(rst), .start(start), .size_code(size_code),
    .lane_addr(lane_addr), .lane_act(lane_act),
    .phase_vld(phase_vld), .phase_idx(phase_idx), .phase_wf(phase_wf),
    .done(done), .total_wf(total_wf), .ideal_wf(ideal_wf),
    .excess_wf(excess_wf), .misalign_err(misalign_err)
  );

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  // request under test
  logic [31:0] A [32];
  logic [31:0] M;
  int SZ;
  int szn, nph;
  int ew [4];
  int etot, eideal, eerr;

  task automatic chk(string rq, string what, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic bit lane_ok(int j);
    return M[j] && ((A[j] & ((32'd4 << szn) - 1)) == 0);
  endfunction

  // reference model of one phase, from the requirements
  function automatic void model_phase(int p, output int wf, output int anyc, output int badc);
    int per = 32 >> szn;
    int lg  = 2 + szn;
    wf = 0; anyc = 0; badc = 0;
    for (int b = 0; b < per; b++) begin
      int cnt = 0;
      for (int j = p*per; j < (p+1)*per; j++) begin
        if (lane_ok(j) && (((A[j] >> lg) & (per - 1)) == b)) begin
          bit seen;
          seen = 0;
          for (int k = p*per; k < j; k++)
            if (lane_ok(k) && A[k] == A[j]) seen = 1;
          if (!seen) cnt++;
        end
      end
      if (cnt > wf) wf = cnt;
    end
    for (int j = p*per; j < (p+1)*per; j++)
      if (M[j]) begin
        if (lane_ok(j)) anyc = 1; else badc = 1;
      end
  endfunction

  task automatic launch();
    szn = (SZ == 3) ? 2 : SZ;
    nph = 1 << szn;
    etot = 0; eideal = 0; eerr = 0;
    for (int p = 0; p < nph; p++) begin
      int a, b;
      model_phase(p, ew[p], a, b);
      etot += ew[p]; eideal += a; eerr |= b;
    end
    for (int i = 0; i < 32; i++) lane_addr[i*32 +: 32] = A[i];
    lane_act  = M;
    size_code = SZ[1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // walks the phases and ends on the cycle where done is expected high
  task automatic collect(string rq, bit intrude);
    for (int p = 0; p < nph; p++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R6", $sformatf("phase_vld p%0d", p), phase_vld, 1);
      chk(rq, $sformatf("phase_idx p%0d", p), phase_idx, p);
      chk(rq, $sformatf("phase_wf p%0d", p), phase_wf, ew[p]);
      if (intrude && p == 0) begin
        // R7: strobe with a different request while busy
        start = 1'b1;
        size_code = 2'd0;
        lane_act = '1;
        for (int i = 0; i < 32; i++) lane_addr[i*32 +: 32] = 32'(i * 4);
      end
    end
    @(negedge clk);
    start = 1'b0;
    chk("R6", "done pulse", done, 1);
    chk("R6", "phase_vld low at done", phase_vld, 0);
    chk(rq, "total_wf", total_wf, etot);
    chk(rq, "ideal_wf", ideal_wf, eideal);
    chk(rq, "excess_wf", excess_wf, etot - eideal);
    chk(rq, "misalign_err", misalign_err, eerr);
  endtask

  task automatic idle_after(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      chk("R7", "no stray phase", phase_vld, 0);
      chk("R6", "done single cycle", done, 0);
      chk("R6", "total held", total_wf, etot);
    end
  endtask

  task automatic fill(int base, int stride);
    for (int i = 0; i < 32; i++) A[i] = 32'(base + stride * i);
    M = '1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R9", "phase_vld", phase_vld, 0);
    chk("R9", "done", done, 0);
    chk("R9", "total_wf", total_wf, 0);
    chk("R9", "ideal_wf", ideal_wf, 0);
    chk("R9", "excess_wf", excess_wf, 0);
    chk("R9", "misalign_err", misalign_err, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9", "phase_vld after release", phase_vld, 0);
  endtask

  task automatic t_w4_patterns();
    SZ = 0; fill(32'h1000, 4); launch(); collect("R2", 0); idle_after(1);
    chk("R2", "linear words wf", ew[0], 1);
    SZ = 0; fill(0, 128); launch(); collect("R2", 0); idle_after(1);
    chk("R2", "stride-128 wf", ew[0], 32);
    SZ = 0; fill(32'h2040, 0); launch(); collect("R2", 0); idle_after(1);
    chk("R2", "broadcast wf", ew[0], 1);
  endtask

  task automatic t_w16_cross_phase();
    SZ = 2; fill(0, 16); launch(); collect("R3", 0); idle_after(1);
    chk("R3", "cross-phase total", etot, 4);
  endtask

  task automatic t_w16_eightway();
    SZ = 2; fill(0, 128); launch(); collect("R2", 0); idle_after(1);
    chk("R2", "8-way phase", ew[0], 8);
  endtask

  task automatic t_w8_and_alias();
    SZ = 1; fill(0, 64); launch(); collect("R1", 0); idle_after(1);
    chk("R1", "8B phase wf", ew[1], 8);
    SZ = 3;
    for (int i = 0; i < 32; i++) A[i] = (i < 16) ? 32'(128 * i) : 32'(16 * i);
    M = 32'h7FFF_FFF0;
    launch(); collect("R1", 0); idle_after(1);
  endtask

  task automatic t_masks();
    SZ = 2; fill(0, 128); M = 32'h0000_FF00; launch(); collect("R5", 0); idle_after(1);
    chk("R5", "masked ideal", eideal, 1);
    SZ = 2; fill(0, 128); M = '0; launch(); collect("R5", 0); idle_after(1);
    chk("R5", "empty total", etot, 0);
  endtask

  task automatic t_misalign();
    SZ = 2; fill(0, 16); A[3] = 32'd132; launch(); collect("R4", 0); idle_after(1);
    chk("R4", "model flags error", eerr, 1);
    SZ = 1; fill(0, 8); A[20] = 32'd164; launch(); collect("R4", 0); idle_after(1);
  endtask

  task automatic t_busy_start();
    SZ = 2; fill(0, 128); M = 32'hF0F0_F0F0; launch(); collect("R7", 1); idle_after(4);
  endtask

  task automatic t_chain();
    SZ = 0; fill(0, 4); launch(); collect("R8", 0);
    // done is high now: the next strobe is issued in this very cycle
    SZ = 2; fill(32'h400, 128); launch(); collect("R8", 0); idle_after(2);
  endtask

  initial begin
    t_reset();
    t_w4_patterns();
    t_w16_cross_phase();
    t_w16_eightway();
    t_w8_and_alias();
    t_masks();
    t_misalign();
    t_busy_start();
    t_chain();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end
endmodule